// File: doc/BRIEF.md
# Seven-Pin I/O Port with Timer Channel Takeover

This block is a seven-pin general-purpose I/O port that sits on a small byte-wide microcontroller bus. Software sees two byte registers: an output latch holding the values to drive, and a direction register whose bits switch each pin's output driver on or off. The block drives per-pin output values and output enables toward the pads. It samples the pad levels through a two-stage synchronizer and returns either the latch bit or the sampled pin for each bit of a port read, depending on that bit's direction setting.

Two pins can be handed to a timer. Each timer channel supplies a pair of edge/level select bits. When that pair is not both zero, the timer's compare value and output enable drive the pin, and the direction bit no longer affects its driver. The direction bit still picks latch or pin for the read-back of that bit. The synchronized pin levels of the two timer pins go back to the timer as capture inputs. Because latch writes are accepted in any direction setting, software can load the latch before it turns a pin into an output, so the first value driven is the one it loaded.

Top module: `gpio_port_tmr`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every direction bit and every latch bit is 0. All pin_oe bits are then 0 and pin_out is 0.
- R2: A write to the direction address (default 4'h9) loads bits 6..0 of the write data on the next clock. A read of that address returns those bits, with bit 7 reading 0 whatever was written to it.
- R3: On a pin that no enabled timer channel owns, pin_oe equals that pin's direction bit: 1 drives the pin, 0 leaves it as an input.
- R4: A read of the data address (default 4'h5) returns the latch bit for each pin whose direction bit is 1. Bit 7 of the read reads 0.
- R5: For each pin whose direction bit is 0, a data read returns the pin level as it was two clock edges earlier, after the two-stage synchronizer.
- R6: A write to the data address updates the latch on the next clock whatever the direction bits hold, and pin_out shows the latch on pins not owned by a timer. A value loaded while a pin is an input is the first value driven once its direction bit is set.
- R7: Channel 0 owns pin 4 and channel 1 owns pin 5. A channel whose two edge/level select bits (tmr_els[1:0] for channel 0, tmr_els[3:2] for channel 1) are not both 0 drives its pin's pin_out from tmr_oc and its pin_oe from tmr_oe, and that pin's direction bit has no effect on the driver.
- R8: While a timer channel owns a pin, that pin's direction bit still selects latch (1) or synchronized pin (0) in a data read.
- R9: tmr_cap[0] and tmr_cap[1] carry the synchronized levels of pins 4 and 5, delayed by two clock edges from pin_in. They do so whether or not the channel is enabled.
- R10: A read of any address other than the data and direction addresses returns 0. A write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 7 | Pad input levels, asynchronous |
| pin_out | output | 7 | Pad output values |
| pin_oe | output | 7 | Pad output enables, 1 = drive |
| tmr_els | input | 4 | Edge/level select pairs, two bits per channel |
| tmr_oc | input | 2 | Timer compare output value per channel |
| tmr_oe | input | 2 | Timer output enable per channel |
| tmr_cap | output | 2 | Synchronized pin level per channel for capture |

## Verification
The assertions assume that the bus and timer inputs hold known values at each clock edge and change only between edges. They also assume that tmr_els stays zero when a direction or latch write is followed by the check on pin_oe or pin_out. The bench changes every input only on the falling clock edge. It steps the timer selects through channel 0 alone, channel 1 alone and both together, with the direction bits of the owned pins set both ways. A behavioural reference model of the registers and the two-stage synchronizer predicts every output on every cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BYTE_W = 8;
    localparam int ELS_W  = 2;

    // a timer channel owns its pin whenever its select pair is nonzero
    function automatic logic chan_on(input logic [ELS_W-1:0] els);
        return |els;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int          PORT_W    = 7,
    parameter int          ADDR_W    = 4,
    parameter logic [3:0]  DATA_ADDR = 4'h5,
    parameter logic [3:0]  DIR_ADDR  = 4'h9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] lat_o,
    output logic [PORT_W-1:0] dir_o
);
    typedef struct packed {
        logic [PORT_W-1:0] lat;
        logic [PORT_W-1:0] dir;
    } regs_t;

    regs_t rg_d, rg_q;

    logic hit_data, hit_dir;
    assign hit_data = bus_wr && (bus_addr == ADDR_W'(DATA_ADDR));
    assign hit_dir  = bus_wr && (bus_addr == ADDR_W'(DIR_ADDR));

    always_comb begin
        rg_d = rg_q;
        if (hit_data) rg_d.lat = bus_wdata[PORT_W-1:0];
        if (hit_dir)  rg_d.dir = bus_wdata[PORT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    generate
        if (PORT_W < BYTE_W) begin : g_spare
            logic unused_wbits;
            assign unused_wbits = ^bus_wdata[BYTE_W-1:PORT_W];
        end
    endgenerate

    assign lat_o = rg_q.lat;
    assign dir_o = rg_q.dir;
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
#(
    parameter int                 PORT_W  = 7,
    parameter int                 NCH     = 2,
    parameter logic [NCH*8-1:0]   CH_PINS = {8'd5, 8'd4}
) (
    input  logic [PORT_W-1:0]    lat_i,
    input  logic [PORT_W-1:0]    dir_i,
    input  logic [PORT_W-1:0]    sync_i,
    input  logic [NCH*ELS_W-1:0] tmr_els,
    input  logic [NCH-1:0]       tmr_oc,
    input  logic [NCH-1:0]       tmr_oe,
    output logic [PORT_W-1:0]    pin_out,
    output logic [PORT_W-1:0]    pin_oe,
    output logic [PORT_W-1:0]    port_rd,
    output logic [NCH-1:0]       tmr_cap
);
    // driver selection: a channel with a nonzero select pair wins its pin
    always_comb begin
        pin_out = lat_i;
        pin_oe  = dir_i;
        for (int p = 0; p < PORT_W; p++) begin
            for (int c = 0; c < NCH; c++) begin
                if (CH_PINS[c*8 +: 8] == 8'(p) &&
                    chan_on(tmr_els[c*ELS_W +: ELS_W])) begin
                    pin_out[p] = tmr_oc[c];
                    pin_oe[p]  = tmr_oe[c];
                end
            end
        end
    end

    // read-back choice always follows the direction bits
    always_comb begin
        for (int p = 0; p < PORT_W; p++) begin
            port_rd[p] = dir_i[p] ? lat_i[p] : sync_i[p];
        end
    end

    genvar gc;
    generate
        for (gc = 0; gc < NCH; gc++) begin : g_cap
            assign tmr_cap[gc] = sync_i[CH_PINS[gc*8 +: 8]];
        end
    endgenerate
endmodule

// File: rtl/gpio_port_tmr.sv
module gpio_port_tmr
    import gpio_pkg::*;
#(
    parameter int               PORT_W    = 7,
    parameter int               ADDR_W    = 4,
    parameter logic [3:0]       DATA_ADDR = 4'h5,
    parameter logic [3:0]       DIR_ADDR  = 4'h9,
    parameter int               NCH       = 2,
    parameter logic [NCH*8-1:0] CH_PINS   = {8'd5, 8'd4}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [PORT_W-1:0]    pin_in,
    output logic [PORT_W-1:0]    pin_out,
    output logic [PORT_W-1:0]    pin_oe,
    input  logic [NCH*ELS_W-1:0] tmr_els,
    input  logic [NCH-1:0]       tmr_oc,
    input  logic [NCH-1:0]       tmr_oe,
    output logic [NCH-1:0]       tmr_cap
);
    logic [PORT_W-1:0] lat_w, dir_w, sync_w, rd_w;

    gpio_regs #(
        .PORT_W(PORT_W), .ADDR_W(ADDR_W),
        .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .lat_o(lat_w), .dir_o(dir_w)
    );

    gpio_sync #(.W(PORT_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(sync_w)
    );

    gpio_pinmux #(.PORT_W(PORT_W), .NCH(NCH), .CH_PINS(CH_PINS)) u_mux (
        .lat_i(lat_w), .dir_i(dir_w), .sync_i(sync_w),
        .tmr_els(tmr_els), .tmr_oc(tmr_oc), .tmr_oe(tmr_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .port_rd(rd_w), .tmr_cap(tmr_cap)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(DATA_ADDR))     bus_rdata[PORT_W-1:0] = rd_w;
        else if (bus_addr == ADDR_W'(DIR_ADDR)) bus_rdata[PORT_W-1:0] = dir_w;
    end
endmodule

// File: rtl/gpio_port_tmr_chk.sv
module gpio_port_tmr_chk
    import gpio_pkg::*;
#(
    parameter int               PORT_W    = 7,
    parameter int               ADDR_W    = 4,
    parameter logic [3:0]       DATA_ADDR = 4'h5,
    parameter logic [3:0]       DIR_ADDR  = 4'h9,
    parameter int               NCH       = 2,
    parameter logic [NCH*8-1:0] CH_PINS   = {8'd5, 8'd4}
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [7:0]           bus_wdata,
    input logic [7:0]           bus_rdata,
    input logic [PORT_W-1:0]    pin_out,
    input logic [PORT_W-1:0]    pin_oe,
    input logic [NCH*ELS_W-1:0] tmr_els,
    input logic [NCH-1:0]       tmr_oc,
    input logic [NCH-1:0]       tmr_oe
);
    a_r2_dir_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(DIR_ADDR)) |-> (bus_rdata[7] == 1'b0));

    a_r4_data_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(DATA_ADDR)) |-> (bus_rdata[7] == 1'b0));

    a_r3_dir_sets_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(DIR_ADDR)) |=>
        ((tmr_els != '0) || (pin_oe == $past(bus_wdata[PORT_W-1:0]))));

    a_r6_latch_to_out: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(DATA_ADDR)) |=>
        ((tmr_els != '0) || (pin_out == $past(bus_wdata[PORT_W-1:0]))));

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(DATA_ADDR) && bus_addr != ADDR_W'(DIR_ADDR))
        |-> (bus_rdata == 8'h00));

    genvar gc;
    generate
        for (gc = 0; gc < NCH; gc++) begin : g_ch
            // R7: an enabled channel drives its pin
            a_r7_timer_drives: assert property (@(posedge clk) disable iff (!rst_n)
                (tmr_els[gc*ELS_W +: ELS_W] != '0) |->
                (pin_out[CH_PINS[gc*8 +: 8]] == tmr_oc[gc] &&
                 pin_oe[CH_PINS[gc*8 +: 8]]  == tmr_oe[gc]));
        end
    endgenerate
endmodule

bind gpio_port_tmr gpio_port_tmr_chk #(
    .PORT_W(PORT_W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR),
    .DIR_ADDR(DIR_ADDR), .NCH(NCH), .CH_PINS(CH_PINS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .tmr_els(tmr_els), .tmr_oc(tmr_oc), .tmr_oe(tmr_oe)
);

// File: tb/sim_gpio_port_tmr.sv
module sim_gpio_port_tmr;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_DATA = 4'h5;
    localparam logic [3:0] A_DIR  = 4'h9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [6:0] pin_in = 7'h00;
    logic [6:0] pin_out, pin_oe;
    logic [3:0] tmr_els = 4'h0;
    logic [1:0] tmr_oc = 2'b00, tmr_oe = 2'b00;
    logic [1:0] tmr_cap;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_tmr u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .tmr_els(tmr_els),
        .tmr_oc(tmr_oc), .tmr_oe(tmr_oe), .tmr_cap(tmr_cap)
    );

    // behavioural reference state
    logic [6:0] m_lat = 0, m_dir = 0;
    logic [6:0] m_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lat <= 0;
            m_dir <= 0;
            m_hist = {7'h00, 7'h00};
        end else begin
            if (bus_wr && bus_addr == A_DATA) m_lat <= bus_wdata[6:0];
            if (bus_wr && bus_addr == A_DIR)  m_dir <= bus_wdata[6:0];
            m_hist.push_back(pin_in);
            void'(m_hist.pop_front());
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        logic [6:0] sy, eo, ev, rd;
        logic [7:0] er;
        sy = m_hist[0];
        eo = m_dir;
        ev = m_lat;
        if (tmr_els[1:0] != 0) begin eo[4] = tmr_oe[0]; ev[4] = tmr_oc[0]; end
        if (tmr_els[3:2] != 0) begin eo[5] = tmr_oe[1]; ev[5] = tmr_oc[1]; end
        for (int i = 0; i < 7; i++) rd[i] = m_dir[i] ? m_lat[i] : sy[i];
        if (bus_addr == A_DATA)     er = {1'b0, rd};
        else if (bus_addr == A_DIR) er = {1'b0, m_dir};
        else                        er = 8'h00;
        check(tag, "pin_oe", pin_oe, eo);
        check(tag, "pin_out", pin_out, ev);
        check(tag, "bus_rdata", bus_rdata, er);
        check(tag, "tmr_cap", tmr_cap, {sy[5], sy[4]});
    endtask

    task automatic step(string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d, string tag);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step(tag);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, string tag);
        bus_addr = a;
        #1 compare(tag);
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        pin_in = 7'h3C;
        step("R1");
        step("R1");
        rst_n = 1'b1;
        check("R1", "pin_oe after reset", pin_oe, 0);
        check("R1", "pin_out after reset", pin_out, 0);
        step("R1");
        // R2: direction register, bit 7 ignored
        wr(A_DIR, 8'hFF, "R2");
        check("R2", "pin_oe all set", pin_oe, 7'h7F);
        rd(A_DIR, "R2");
        check("R2", "dir read", bus_rdata, 8'h7F);
        // R6: preload latch while pins are inputs
        wr(A_DIR, 8'h00, "R3");
        wr(A_DATA, 8'hD5, "R6");
        check("R6", "preloaded latch on pin_out", pin_out, 7'h55);
        check("R3", "inputs not driven", pin_oe, 7'h00);
        // R5: pin levels through the synchronizer
        pin_in = 7'h2A;
        rd(A_DATA, "R5");
        rd(A_DATA, "R5");
        check("R5", "pin read after two edges", bus_rdata, 8'h2A);
        check("R9", "capture inputs", tmr_cap, 2'b10);
        // R3/R4/R6: mixed direction
        wr(A_DIR, 8'h0F, "R3");
        check("R6", "first driven value is preload", pin_out & pin_oe, 7'h05);
        rd(A_DATA, "R4");
        check("R4", "mixed read", bus_rdata, 8'h25);
        // R7: channel 0 only, dir bit 4 clear
        tmr_els = 4'b0001; tmr_oc = 2'b01; tmr_oe = 2'b01;
        rd(A_DATA, "R7");
        check("R7", "ch0 drives pin4", pin_oe[4], 1);
        // R7/R8: channel 1 only, dir bit 5 set vs clear
        tmr_els = 4'b1000; tmr_oc = 2'b00; tmr_oe = 2'b10;
        wr(A_DIR, 8'h20, "R7");
        check("R7", "ch1 owns pin5 oe", pin_oe, 7'h20);
        check("R7", "ch1 value", pin_out[5], 0);
        rd(A_DATA, "R8");
        check("R8", "owned pin reads latch", bus_rdata[5], 0);
        wr(A_DIR, 8'h10, "R8");
        tmr_oe = 2'b00;
        rd(A_DATA, "R8");
        check("R8", "owned pin reads pin", bus_rdata[5], 1);
        check("R7", "dir bit4 drives with ch0 off", pin_oe, 7'h10);
        // both channels, changing pins
        tmr_els = 4'b0110; tmr_oc = 2'b10; tmr_oe = 2'b11;
        pin_in = 7'h11;
        for (int k = 0; k < 4; k++) rd(A_DATA, "R9");
        check("R9", "capture after change", tmr_cap, 2'b01);
        tmr_els = 4'h0;
        // R10: unmapped address
        wr(4'h3, 8'hFF, "R10");
        rd(4'h3, "R10");
        check("R10", "unmapped read", bus_rdata, 0);
        rd(A_DIR, "R10");
        check("R10", "dir untouched", bus_rdata, 8'h10);
        wr(A_DATA, 8'h7F, "R6");
        wr(A_DIR, 8'h7F, "R4");
        rd(A_DATA, "R4");
        check("R4", "all latch read", bus_rdata, 8'h7F);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule